// File: doc/BRIEF.md
# Translation Cache with Accessed/Dirty Update

The block is a small fully-associative cache of completed address translations. It sits in front of a page-table walker. A lookup presents an address-space identifier, a virtual address and an access kind. On a hit the stored leaf page-table entry is checked again against the access, and the physical address is formed from the stored base and the page offset bits. Large pages fit in one entry because every entry carries a mask sized to its page.

A cached leaf may lack the accessed bit, or the dirty bit a store needs. In that case a platform enable input decides what happens. With the enable low, the translation fails with a PTE-update fault. With it high, the block writes the updated 64-bit entry to memory at the stored entry address and refreshes the cached copy.

On a miss the walker delivers a fill. The same accessed/dirty handling runs on the fill. The cache stores the entry as it stands after that handling, and stores nothing if the handling faults. A flush input removes every entry, or only the non-global entries of one identifier. Replacement follows a round-robin pointer.

Top module: `xlat_tlb`

## Requirements
- R1: After reset no response is valid, no memory write is issued, and every lookup misses. Each lookup or fill gets a registered response one cycle later.
- R2: An entry matches when it is valid, its virtual tag equals the address above its page mask, and either its identifier equals the lookup identifier or its global flag is set. A miss returns rsp_miss=1, cause 0 and address 0.
- R3: A leaf stored at level L (0, 1 or 2) covers the low 12+9*L address bits. The returned address is (PPN from entry bits 53:10, shifted left 12, with the covered bits cleared) OR (virtual address AND covered-bits mask).
- R4: On a hit the permission is checked again from entry bits R=1, W=2, X=3, U=4. Access codes are 0 read, 1 write, 2 execute. A read needs R, or X with make-executable-readable set. A write needs W. An execute needs X. User mode needs U. Supervisor mode may use a U page only with the user-access permit set, and never for execute. A failure gives cause 1 and address 0, and issues no memory write.
- R5: If a permitted access needs A (bit 6) set, or a write needs D (bit 7) set, and ad_update_en is low, the result is cause 2 with no memory write, and the cached entry stays unchanged.
- R6: If such an update is enabled on a hit, the block writes the entry OR A (OR D for writes) to the stored entry address in the same cycle. It returns the translated address, and the cached copy then holds the new bits.
- R7: A fill that needs an update faults without storing anything. With the update enabled and mem_wr_err high, it faults with cause 3. With the update disabled, it faults with cause 2.
- R8: A fill that succeeds stores the entry after any A/D update and returns the translated address for its virtual address.
- R9: On a hit, an enabled update whose memory write reports mem_wr_err returns cause 3 and leaves the cached entry unchanged.
- R10: A flush with flush_by_asid low removes every entry, global ones included.
- R11: A flush with flush_by_asid high removes only the non-global entries whose identifier equals flush_asid.
- R12: Fills replace entries in round-robin order, so the ninth fill into eight entries evicts the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_asid | input | 16 | Lookup identifier (narrower identifiers zero-extended) |
| req_va | input | 39 | Lookup virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_user | input | 1 | Access made in user mode |
| req_mxr | input | 1 | Executable pages readable |
| req_sum | input | 1 | Supervisor may touch user pages |
| fill_valid | input | 1 | Walker fill (has priority over lookup) |
| fill_asid | input | 16 | Fill identifier |
| fill_va | input | 39 | Fill virtual address |
| fill_acc | input | 2 | Access kind that caused the walk |
| fill_pte | input | 64 | Leaf entry from the walk |
| fill_pte_addr | input | 56 | Physical address of the leaf entry |
| fill_level | input | 2 | Level of the leaf |
| fill_global | input | 1 | Leaf is global |
| flush_en | input | 1 | Flush request |
| flush_by_asid | input | 1 | Restrict flush to one identifier |
| flush_asid | input | 16 | Identifier to flush |
| ad_update_en | input | 1 | Platform enable for A/D writeback |
| mem_wr_en | output | 1 | 8-byte entry write to memory |
| mem_wr_addr | output | 56 | Entry write address |
| mem_wr_data | output | 64 | Updated entry |
| mem_wr_err | input | 1 | Same-cycle write error |
| rsp_valid | output | 1 | Response valid |
| rsp_miss | output | 1 | Lookup missed |
| rsp_cause | output | 2 | 0 none, 1 permission, 2 PTE update, 3 access |
| rsp_pa | output | 56 | Translated physical address |

## Verification
The address check sweeps all three page levels with several offsets each. This separates a mask sized per level from one that is fixed. The permission check runs every combination of the R/W/X/U flags against every access kind, privilege and permit setting, and compares with a model. Paired lookups before and after an update show whether the cached entry was changed: the update was disabled, the write failed, or the write succeeded. Identifier and global patterns, the two flush forms and a nine-fill sequence tell apart match, removal and eviction order.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int PG_W   = 12;
    localparam int VPN_W  = 9;
    localparam int LEVELS = 3;
    localparam int VA_W   = PG_W + LEVELS * VPN_W;
    localparam int PPN_W  = 44;
    localparam int PA_W   = PPN_W + PG_W;
    localparam int PTE_W  = 64;
    localparam int ASID_W = 16;
    localparam int LVL_W  = $clog2(LEVELS);

    localparam int F_R = 1;
    localparam int F_W = 2;
    localparam int F_X = 3;
    localparam int F_U = 4;
    localparam int F_A = 6;
    localparam int F_D = 7;
    localparam int PPN_LSB = 10;

    typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_EXEC = 2'd2} acc_e;
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0, CAUSE_PERM = 2'd1, CAUSE_PTE_UPD = 2'd2, CAUSE_ACCESS = 2'd3
    } cause_e;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VA_W-1:0]   tag;
        logic [VA_W-1:0]   mask;
        logic [PA_W-1:0]   pbase;
        logic [PTE_W-1:0]  pte;
        logic [PA_W-1:0]   pte_addr;
        logic [LVL_W-1:0]  level;
        logic              glob;
    } tlb_ent_t;

    function automatic logic [VA_W-1:0] level_mask(input logic [LVL_W-1:0] lvl);
        logic [VA_W-1:0] m;
        for (int i = 0; i < VA_W; i++)
            m[i] = (i < PG_W + int'(lvl) * VPN_W);
        return m;
    endfunction

    function automatic logic [PA_W-1:0] pte_base(input logic [PTE_W-1:0] pte,
                                                 input logic [VA_W-1:0] mask);
        logic [PA_W-1:0] full;
        full = {pte[PPN_LSB +: PPN_W], {PG_W{1'b0}}};
        return full & ~{{(PA_W-VA_W){1'b0}}, mask};
    endfunction

    function automatic logic perm_ok(input logic [PTE_W-1:0] pte, input acc_e acc,
                                     input logic user, input logic mxr, input logic sum);
        logic ok;
        case (acc)
            ACC_READ:  ok = pte[F_R] | (mxr & pte[F_X]);
            ACC_WRITE: ok = pte[F_W];
            ACC_EXEC:  ok = pte[F_X];
            default:   ok = 1'b0;
        endcase
        if (user)
            ok = ok & pte[F_U];
        else if (pte[F_U])
            ok = ok & sum & (acc != ACC_EXEC);
        return ok;
    endfunction
endpackage

// File: rtl/tlb_ad_unit.sv
module tlb_ad_unit
    import tlb_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    input  acc_e             acc,
    input  logic             check_perm,
    input  logic             user,
    input  logic             mxr,
    input  logic             sum,
    input  logic             upd_en,
    input  logic             mem_err,
    output cause_e           cause,
    output logic             wr_mem,
    output logic [PTE_W-1:0] new_pte
);
    logic allowed;
    logic need_a;
    logic need_d;
    logic need;

    always_comb begin
        allowed = !check_perm || perm_ok(pte, acc, user, mxr, sum);
        need_a  = !pte[F_A];
        need_d  = (acc == ACC_WRITE) && !pte[F_D];
        need    = need_a || need_d;
        new_pte = pte;
        new_pte[F_A] = 1'b1;
        if (acc == ACC_WRITE)
            new_pte[F_D] = 1'b1;
        if (!need)
            new_pte = pte;
        wr_mem = allowed && need && upd_en;
        if (!allowed)
            cause = CAUSE_PERM;
        else if (need && !upd_en)
            cause = CAUSE_PTE_UPD;
        else if (wr_mem && mem_err)
            cause = CAUSE_ACCESS;
        else
            cause = CAUSE_NONE;
    end
endmodule

// File: rtl/tlb_rr.sv
module tlb_rr #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_va,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output tlb_ent_t          hit_ent,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_ent_t          wr_ent,
    input  logic              flush_en,
    input  logic              flush_by_asid,
    input  logic [ASID_W-1:0] flush_asid
);
    tlb_ent_t [ENTRIES-1:0] ent_arr;
    logic     [ENTRIES-1:0] match_v;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tlb_ent_t ent_q;
        logic     drop;
        assign drop = flush_en &&
                      (!flush_by_asid || (!ent_q.glob && ent_q.asid == flush_asid));
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else begin
                if (wr_en && wr_idx == IDX_W'(g))
                    ent_q <= wr_ent;
                if (drop)
                    ent_q.valid <= 1'b0;
            end
        end
        assign ent_arr[g] = ent_q;
        assign match_v[g] = ent_q.valid && (ent_q.glob || ent_q.asid == lk_asid) &&
                            ((lk_va & ~ent_q.mask) == ent_q.tag);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (match_v[i])
                hit_idx = IDX_W'(i);
        hit     = |match_v;
        hit_ent = ent_arr[hit_idx];
    end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [1:0]        req_acc,
    input  logic              req_user,
    input  logic              req_mxr,
    input  logic              req_sum,
    input  logic              fill_valid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [1:0]        fill_acc,
    input  logic [PTE_W-1:0]  fill_pte,
    input  logic [PA_W-1:0]   fill_pte_addr,
    input  logic [LVL_W-1:0]  fill_level,
    input  logic              fill_global,
    input  logic              flush_en,
    input  logic              flush_by_asid,
    input  logic [ASID_W-1:0] flush_asid,
    input  logic              ad_update_en,
    output logic              mem_wr_en,
    output logic [PA_W-1:0]   mem_wr_addr,
    output logic [PTE_W-1:0]  mem_wr_data,
    input  logic              mem_wr_err,
    output logic              rsp_valid,
    output logic              rsp_miss,
    output logic [1:0]        rsp_cause,
    output logic [PA_W-1:0]   rsp_pa
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    tlb_ent_t         hit_ent;
    logic [IDX_W-1:0] rr_ptr;
    logic             rr_adv;
    logic             st_wr_en;
    logic [IDX_W-1:0] st_wr_idx;
    tlb_ent_t         st_wr_ent;

    logic             active;
    acc_e             op_acc;
    logic [PTE_W-1:0] op_pte;
    cause_e           cause;
    logic             wr_mem;
    logic [PTE_W-1:0] new_pte;
    logic [VA_W-1:0]  fill_mask;
    tlb_ent_t         fill_ent;
    logic [PA_W-1:0]  pa;

    tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst(rst),
        .lk_asid(req_asid), .lk_va(req_va),
        .hit(hit), .hit_idx(hit_idx), .hit_ent(hit_ent),
        .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_ent(st_wr_ent),
        .flush_en(flush_en), .flush_by_asid(flush_by_asid), .flush_asid(flush_asid)
    );

    tlb_rr #(.ENTRIES(ENTRIES)) u_rr (
        .clk(clk), .rst(rst), .adv(rr_adv), .ptr(rr_ptr)
    );

    tlb_ad_unit u_ad (
        .pte(op_pte), .acc(op_acc), .check_perm(!fill_valid),
        .user(req_user), .mxr(req_mxr), .sum(req_sum),
        .upd_en(ad_update_en), .mem_err(mem_wr_err),
        .cause(cause), .wr_mem(wr_mem), .new_pte(new_pte)
    );

    always_comb begin
        active = fill_valid || (req_valid && hit);
        op_acc = fill_valid ? acc_e'(fill_acc) : acc_e'(req_acc);
        op_pte = fill_valid ? fill_pte : hit_ent.pte;

        fill_mask         = level_mask(fill_level);
        fill_ent.valid    = 1'b1;
        fill_ent.asid     = fill_asid;
        fill_ent.tag      = fill_va & ~fill_mask;
        fill_ent.mask     = fill_mask;
        fill_ent.pbase    = pte_base(new_pte, fill_mask);
        fill_ent.pte      = new_pte;
        fill_ent.pte_addr = fill_pte_addr;
        fill_ent.level    = fill_level;
        fill_ent.glob     = fill_global;

        mem_wr_en   = active && wr_mem;
        mem_wr_addr = fill_valid ? fill_pte_addr : hit_ent.pte_addr;
        mem_wr_data = new_pte;

        rr_adv    = fill_valid && cause == CAUSE_NONE;
        st_wr_en  = rr_adv || (!fill_valid && req_valid && hit && wr_mem && cause == CAUSE_NONE);
        st_wr_idx = fill_valid ? rr_ptr : hit_idx;
        st_wr_ent = hit_ent;
        st_wr_ent.pte = new_pte;
        if (fill_valid)
            st_wr_ent = fill_ent;

        if (fill_valid)
            pa = fill_ent.pbase | {{(PA_W-VA_W){1'b0}}, fill_va & fill_mask};
        else
            pa = hit_ent.pbase | {{(PA_W-VA_W){1'b0}}, req_va & hit_ent.mask};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_cause <= CAUSE_NONE;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= fill_valid || req_valid;
            rsp_miss  <= !fill_valid && req_valid && !hit;
            rsp_cause <= active ? cause : CAUSE_NONE;
            rsp_pa    <= (active && cause == CAUSE_NONE) ? pa : '0;
        end
    end
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             fill_valid,
    input logic             ad_update_en,
    input logic             mem_wr_en,
    input logic [PTE_W-1:0] mem_wr_data,
    input logic             mem_wr_err,
    input logic             rsp_valid,
    input logic             rsp_miss,
    input logic [1:0]       rsp_cause,
    input logic [PA_W-1:0]  rsp_pa
);
    AST_RSP_FOLLOWS_OP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid || fill_valid)); // R1

    AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_miss) |-> (rsp_cause == 2'd0 && rsp_pa == '0)); // R2

    AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_cause != 2'd0) |-> rsp_pa == '0); // R4

    AST_WR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> ad_update_en); // R5

    AST_UPD_FAULT_EN_LOW: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_cause == 2'd2) |-> !$past(ad_update_en)); // R5

    AST_WR_SETS_A: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> mem_wr_data[F_A]); // R6

    AST_WR_ERR_ACCESS: assert property (@(posedge clk) disable iff (rst)
        $past(mem_wr_en && mem_wr_err) |-> (rsp_valid && rsp_cause == 2'd3)); // R7
endmodule

bind xlat_tlb xlat_tlb_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .fill_valid(fill_valid),
    .ad_update_en(ad_update_en), .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data),
    .mem_wr_err(mem_wr_err), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss),
    .rsp_cause(rsp_cause), .rsp_pa(rsp_pa)
);

// File: tb/tb_xlat_tlb.sv
module tb_xlat_tlb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid = 0;
    logic [15:0] req_asid = 0;
    logic [38:0] req_va = 0;
    logic [1:0]  req_acc = 0;
    logic        req_user = 0, req_mxr = 0, req_sum = 0;
    logic        fill_valid = 0;
    logic [15:0] fill_asid = 0;
    logic [38:0] fill_va = 0;
    logic [1:0]  fill_acc = 0;
    logic [63:0] fill_pte = 0;
    logic [55:0] fill_pte_addr = 0;
    logic [1:0]  fill_level = 0;
    logic        fill_global = 0;
    logic        flush_en = 0, flush_by_asid = 0;
    logic [15:0] flush_asid = 0;
    logic        ad_update_en = 0;
    logic        mem_wr_en;
    logic [55:0] mem_wr_addr;
    logic [63:0] mem_wr_data;
    logic        mem_wr_err = 0;
    logic        rsp_valid, rsp_miss;
    logic [1:0]  rsp_cause;
    logic [55:0] rsp_pa;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic        c_wr;
    logic [55:0] c_addr;
    logic [63:0] c_data;

    xlat_tlb dut (.*);

    always #5 clk = ~clk;

    task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_pte(logic [43:0] ppn, logic [7:0] fl);
        return {10'd0, ppn, 2'b00, fl};
    endfunction

    function automatic logic [55:0] exp_pa(logic [43:0] ppn, int lvl, logic [38:0] va);
        logic [55:0] m;
        m = (56'd1 << (12 + 9 * lvl)) - 56'd1;
        return ({ppn, 12'd0} & ~m) | ({17'd0, va} & m);
    endfunction

    function automatic bit exp_perm(logic [7:0] f, int acc, bit u, bit mxr, bit sum);
        bit ok;
        ok = (acc == 0) ? (f[1] || (mxr && f[3])) : (acc == 1) ? f[2] : f[3];
        if (u) ok = ok && f[4];
        else if (f[4]) ok = ok && sum && acc != 2;
        return ok;
    endfunction

    task automatic lookup(logic [15:0] asid, logic [38:0] va, int acc, bit u, bit mxr,
                          bit sum, bit en, bit err);
        @(negedge clk);
        req_valid = 1; req_asid = asid; req_va = va; req_acc = 2'(acc);
        req_user = u; req_mxr = mxr; req_sum = sum; ad_update_en = en; mem_wr_err = err;
        #1;
        c_wr = mem_wr_en; c_addr = mem_wr_addr; c_data = mem_wr_data;
        @(negedge clk);
        req_valid = 0; mem_wr_err = 0; ad_update_en = 0;
    endtask

    task automatic fill(logic [15:0] asid, logic [38:0] va, logic [63:0] pte,
                        logic [55:0] pa_addr, int lvl, bit g, int acc, bit en, bit err);
        @(negedge clk);
        fill_valid = 1; fill_asid = asid; fill_va = va; fill_pte = pte;
        fill_pte_addr = pa_addr; fill_level = 2'(lvl); fill_global = g; fill_acc = 2'(acc);
        ad_update_en = en; mem_wr_err = err;
        #1;
        c_wr = mem_wr_en; c_addr = mem_wr_addr; c_data = mem_wr_data;
        @(negedge clk);
        fill_valid = 0; mem_wr_err = 0; ad_update_en = 0;
    endtask

    task automatic flush(bit by_asid, logic [15:0] asid);
        @(negedge clk);
        flush_en = 1; flush_by_asid = by_asid; flush_asid = asid;
        @(negedge clk);
        flush_en = 0; flush_by_asid = 0;
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            summary();
        end
    end

    initial begin
        logic [7:0] fl;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 mem_wr_en", mem_wr_en, 0);
        lookup(16'd1, 39'h1000, 0, 0, 0, 0, 0, 0);
        chk("R1 miss after reset", {rsp_valid, rsp_miss}, 2'b11);

        // R3 and R8: per-level address composition
        for (int lv = 0; lv < 3; lv++) begin
            logic [43:0] ppn;
            logic [38:0] vbase;
            ppn = 44'hABC00 << (9 * lv);
            vbase = 39'h12_3456_7000 & ~((39'd1 << (12 + 9 * lv)) - 1);
            flush(0, 0);
            fill(16'd2, vbase, mk_pte(ppn, 8'hCF), 56'h8000, lv, 0, 0, 1, 0);
            chk("R8 fill pa", rsp_pa, exp_pa(ppn, lv, vbase));
            for (int k = 0; k < 4; k++) begin
                logic [38:0] va;
                va = vbase | ((39'h15A5A5 * (k + 1)) & ((39'd1 << (12 + 9 * lv)) - 1));
                lookup(16'd2, va, k % 3, 0, 0, 0, 0, 0);
                chk("R3 hit pa", {rsp_miss, rsp_cause, rsp_pa}, {3'b000, exp_pa(ppn, lv, va)});
            end
        end

        // R2: identifier and global matching
        flush(0, 0);
        fill(16'd3, 39'h4000, mk_pte(44'h11, 8'hCF), 56'h100, 0, 0, 0, 0, 0);
        lookup(16'd4, 39'h4010, 0, 0, 0, 0, 0, 0);
        chk("R2 other asid misses", {rsp_miss, rsp_cause, rsp_pa}, {1'b1, 2'd0, 56'd0});
        lookup(16'd3, 39'h4010, 0, 0, 0, 0, 0, 0);
        chk("R2 same asid hits", {rsp_miss, rsp_pa}, {1'b0, 56'h11010});
        fill(16'd3, 39'h9000, mk_pte(44'h22, 8'hEF), 56'h108, 0, 1, 0, 0, 0);
        lookup(16'd9, 39'h9004, 0, 0, 0, 0, 0, 0);
        chk("R2 global any asid", {rsp_miss, rsp_pa}, {1'b0, 56'h22004});

        // R4: permission recheck sweep
        for (int f = 0; f < 16; f++) begin
            fl = {2'b11, 1'b0, 4'(f), 1'b1};
            flush(0, 0);
            fill(16'd1, 39'h7000, mk_pte(44'h33, fl), 56'h200, 0, 0, 0, 0, 0);
            for (int a = 0; a < 3; a++)
                for (int m = 0; m < 8; m++) begin
                    bit ok;
                    ok = exp_perm(fl, a, m[0], m[1], m[2]);
                    lookup(16'd1, 39'h7008, a, m[0], m[1], m[2], 1, 0);
                    chk("R4 perm", {c_wr, rsp_cause, rsp_pa},
                        ok ? {3'b000, 56'h33008} : {3'b001, 56'd0});
                end
        end

        // R5: update disabled faults and leaves entry as it was
        flush(0, 0);
        fill(16'd1, 39'h5000, mk_pte(44'h44, 8'h47), 56'h300, 0, 0, 0, 0, 0);
        lookup(16'd1, 39'h5000, 1, 0, 0, 0, 0, 0);
        chk("R5 pte-update fault", {c_wr, rsp_cause, rsp_pa}, {3'b010, 56'd0});
        lookup(16'd1, 39'h5000, 1, 0, 0, 0, 0, 0);
        chk("R5 entry unchanged", rsp_cause, 2'd2);

        // R6: enabled update writes memory and cached copy
        lookup(16'd1, 39'h5020, 1, 0, 0, 0, 1, 0);
        chk("R6 write issued", {c_wr, c_addr}, {1'b1, 56'h300});
        chk("R6 write data", c_data, mk_pte(44'h44, 8'hC7));
        chk("R6 pa", {rsp_cause, rsp_pa}, {2'd0, 56'h44020});
        lookup(16'd1, 39'h5020, 1, 0, 0, 0, 0, 0);
        chk("R6 cached D set", {c_wr, rsp_cause}, 3'b000);

        // R9: hit write error leaves entry unchanged
        fill(16'd1, 39'h6000, mk_pte(44'h55, 8'h07), 56'h308, 0, 0, 1, 0, 0);
        chk("R7 disabled fill fault", rsp_cause, 2'd2);
        fill(16'd1, 39'h6000, mk_pte(44'h55, 8'h07), 56'h308, 0, 0, 0, 1, 1);
        chk("R7 fill write error", {c_wr, rsp_cause}, 3'b111);
        lookup(16'd1, 39'h6000, 0, 0, 0, 0, 0, 0);
        chk("R7 no fill stored", rsp_miss, 1);
        fill(16'd1, 39'h6000, mk_pte(44'h55, 8'h07), 56'h308, 0, 0, 0, 1, 0);
        chk("R8 fill write data", {c_wr, c_data}, {1'b1, mk_pte(44'h55, 8'h47)});
        lookup(16'd1, 39'h6000, 0, 0, 0, 0, 0, 0);
        chk("R8 stored updated pte", {c_wr, rsp_cause}, 3'b000);
        lookup(16'd1, 39'h6000, 1, 0, 0, 0, 1, 1);
        chk("R9 hit write error", {c_wr, rsp_cause, rsp_pa}, {3'b111, 56'd0});
        lookup(16'd1, 39'h6000, 1, 0, 0, 0, 1, 0);
        chk("R9 entry kept old D", {c_wr, c_data}, {1'b1, mk_pte(44'h55, 8'hC7)});

        // R11: flush by identifier
        flush(0, 0);
        fill(16'd5, 39'h1000, mk_pte(44'h1, 8'hCF), 0, 0, 0, 0, 0, 0);
        fill(16'd5, 39'h2000, mk_pte(44'h2, 8'hCF), 0, 0, 1, 0, 0, 0);
        fill(16'd6, 39'h3000, mk_pte(44'h3, 8'hCF), 0, 0, 0, 0, 0, 0);
        flush(1, 16'd5);
        lookup(16'd5, 39'h1000, 0, 0, 0, 0, 0, 0);
        chk("R11 own nonglobal gone", rsp_miss, 1);
        lookup(16'd5, 39'h2000, 0, 0, 0, 0, 0, 0);
        chk("R11 global kept", {rsp_miss, rsp_pa}, {1'b0, 56'h2000});
        lookup(16'd6, 39'h3000, 0, 0, 0, 0, 0, 0);
        chk("R11 other asid kept", {rsp_miss, rsp_pa}, {1'b0, 56'h3000});

        // R10: full flush
        flush(0, 0);
        lookup(16'd5, 39'h2000, 0, 0, 0, 0, 0, 0);
        chk("R10 global gone", rsp_miss, 1);
        lookup(16'd6, 39'h3000, 0, 0, 0, 0, 0, 0);
        chk("R10 all gone", rsp_miss, 1);

        // R12: round-robin replacement
        for (int i = 0; i < 9; i++)
            fill(16'd7, 39'(i + 1) << 12, mk_pte(44'(i + 16), 8'hCF), 0, 0, 0, 0, 0, 0);
        lookup(16'd7, 39'h1000, 0, 0, 0, 0, 0, 0);
        chk("R12 oldest evicted", rsp_miss, 1);
        for (int i = 1; i < 9; i++) begin
            lookup(16'd7, 39'(i + 1) << 12, 0, 0, 0, 0, 0, 0);
            chk("R12 newer kept", {rsp_miss, rsp_pa}, {1'b0, 44'(i + 16), 12'd0});
        end

        done = 1;
        summary();
    end
endmodule